// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the eight condition and control flags of a small processor core, together with the logic that updates them. The core reads and writes the whole byte through an I/O port at a fixed address. The ALU changes individual flags through a value vector and a per-flag update mask. The interrupt controller clears the global enable when it accepts an interrupt. A return strobe sets the enable again.

Two single-bit copy paths connect the T flag to a register operand. A bit-store moves one selected operand bit into T. A bit-load returns the operand with that bit replaced by T.

The block also gates the incoming interrupt requests. It passes them on only while the global enable is set, and only for sources whose mask bit is set. The sign flag is never stored on its own terms. After every update it is recomputed as the XOR of the negative and overflow flags.

Field order is I(7) T(6) H(5) S(4) V(3) N(2) Z(1) C(0).

Top module: `status_flags`

## Requirements
- R1: After reset `flags` is 0x00.
- R2: While `io_addr` equals the register address (default 0x3F), `io_rdata` shows `flags`; at any other address `io_rdata` is 0x00 and a write has no effect on `flags`.
- R3: A write at the register address loads `io_wdata` into all flags on the next clock, with bit 4 replaced by bit 2 XOR bit 3 of the written byte.
- R4: Without an I/O write, each flag whose `alu_upd` bit is 1 takes the matching `alu_val` bit and every other flag holds; an I/O write in the same cycle takes precedence over the ALU update.
- R5: `flags[4]` equals `flags[2]` XOR `flags[3]` in every cycle.
- R6: `irq_pend` equals `irq_req & irq_mask` when `flags[7]` is 1, and is all zero when `flags[7]` is 0.
- R7: `irq_take` makes `flags[7]` 0 on the next clock, even when an I/O write of the same cycle sets bit 7; the other bits of that write still load.
- R8: `reti` alone makes `flags[7]` 1 on the next clock; with `irq_take` in the same cycle `flags[7]` ends at 0.
- R9: `bst` copies `opnd[bit_sel]` into `flags[6]` on the next clock, overriding a write or ALU value for that bit.
- R10: `bld_out` equals `opnd` with bit `bit_sel` replaced by `flags[6]`, combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | AW (6) | I/O address |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data |
| alu_upd | input | 8 | Per-flag update mask from the ALU |
| alu_val | input | 8 | New flag values from the ALU |
| bst | input | 1 | Bit-store strobe (operand bit to T) |
| bit_sel | input | 3 | Operand bit index for bit copies |
| opnd | input | 8 | Register operand |
| bld_out | output | 8 | Operand with selected bit replaced by T |
| irq_req | input | NIRQ (4) | Raw interrupt requests |
| irq_mask | input | NIRQ (4) | Individual interrupt enables |
| irq_pend | output | NIRQ (4) | Gated interrupt requests |
| irq_take | input | 1 | Interrupt accepted this cycle |
| reti | input | 1 | Return-from-interrupt strobe |
| flags | output | 8 | Current flag byte |

## Verification
The assertions assume that all inputs are known values whenever reset is released. They also assume that `bit_sel` always indexes a real operand bit. Beyond that, any mix of write, ALU, copy, accept and return strobes may occur in the same cycle, so the stimulus draws every strobe on its own each cycle. This deliberately causes many collisions. A few directed cycles force the write-against-accept and return-against-accept cases, a masked ALU update, and a write to a foreign address.

// File: rtl/status_flags.sv
module status_flags #(
  parameter int AW = 6,
  parameter logic [AW-1:0] ADDR = 6'h3F,
  parameter int NIRQ = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   io_addr,
  input  logic            io_wr,
  input  logic [7:0]      io_wdata,
  output logic [7:0]      io_rdata,
  input  logic [7:0]      alu_upd,
  input  logic [7:0]      alu_val,
  input  logic            bst,
  input  logic [2:0]      bit_sel,
  input  logic [7:0]      opnd,
  output logic [7:0]      bld_out,
  input  logic [NIRQ-1:0] irq_req,
  input  logic [NIRQ-1:0] irq_mask,
  output logic [NIRQ-1:0] irq_pend,
  input  logic            irq_take,
  input  logic            reti,
  output logic [7:0]      flags
);
  localparam int IB = 7, TB = 6, SB = 4, VB = 3, NB = 2;

  logic [7:0] sr, nxt;
  wire hit = (io_addr == ADDR);

  always_comb begin
    nxt = (io_wr && hit) ? io_wdata : ((sr & ~alu_upd) | (alu_val & alu_upd));
    if (bst) nxt[TB] = opnd[bit_sel];
    if (irq_take) nxt[IB] = 1'b0;
    else if (reti) nxt[IB] = 1'b1;
    nxt[SB] = nxt[NB] ^ nxt[VB];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sr <= '0;
    else        sr <= nxt;
  end

  always_comb begin
    bld_out = opnd;
    bld_out[bit_sel] = sr[TB];
  end

  assign flags    = sr;
  assign io_rdata = hit ? sr : 8'h00;
  assign irq_pend = irq_req & irq_mask & {NIRQ{sr[IB]}};
endmodule

module status_flags_chk #(
  parameter int AW = 6,
  parameter logic [AW-1:0] ADDR = 6'h3F,
  parameter int NIRQ = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   io_addr,
  input logic            io_wr,
  input logic [7:0]      io_wdata,
  input logic [7:0]      alu_upd,
  input logic            bst,
  input logic [2:0]      bit_sel,
  input logic [7:0]      opnd,
  input logic [7:0]      bld_out,
  input logic [NIRQ-1:0] irq_req,
  input logic [NIRQ-1:0] irq_mask,
  input logic [NIRQ-1:0] irq_pend,
  input logic            irq_take,
  input logic            reti,
  input logic [7:0]      flags
);
  wire wr_hit = io_wr && (io_addr == ADDR);

  // R5
  sign_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags[4] == (flags[2] ^ flags[3]));

  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flags[7] |-> irq_pend == '0);

  // R7
  take_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> !flags[7]);

  // R8
  reti_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !irq_take) |=> flags[7]);

  // R9
  bst_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bst |=> flags[6] == $past(opnd[bit_sel]));

  // R10
  bld_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bld_out[bit_sel] == flags[6]);

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit && !bst && !irq_take && !reti && alu_upd == 8'h00) |=> $stable(flags));

  // R3
  wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !bst && !irq_take && !reti) |=>
      flags == {$past(io_wdata[7:5]), $past(io_wdata[2]) ^ $past(io_wdata[3]), $past(io_wdata[3:0])});
endmodule

bind status_flags status_flags_chk #(.AW(AW), .ADDR(ADDR), .NIRQ(NIRQ)) u_chk (.*);

// File: tb/status_flags_bench.sv
module status_flags_bench;
  localparam int CLK_P = 10;
  localparam int AW = 6;
  localparam logic [AW-1:0] ADDR = 6'h3F;
  localparam int NIRQ = 4;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] io_addr = '0;
  logic io_wr = 0, bst = 0, irq_take = 0, reti = 0;
  logic [7:0] io_wdata = 0, alu_upd = 0, alu_val = 0, opnd = 0;
  logic [2:0] bit_sel = 0;
  logic [NIRQ-1:0] irq_req = 0, irq_mask = 0;
  wire [7:0] io_rdata, bld_out, flags;
  wire [NIRQ-1:0] irq_pend;

  int tests = 0, fails = 0;
  logic [7:0] m;

  always #(CLK_P/2) clk = ~clk;

  status_flags #(.AW(AW), .ADDR(ADDR), .NIRQ(NIRQ)) u_status_flags (.*);

  function automatic logic [7:0] model(logic [7:0] cur);
    logic [7:0] r;
    r = cur;
    if (io_wr && io_addr == ADDR) r = io_wdata;
    else for (int i = 0; i < 8; i++) if (alu_upd[i]) r[i] = alu_val[i];
    if (bst) r[6] = opnd[bit_sel];
    if (irq_take) r[7] = 0; else if (reti) r[7] = 1;
    r[4] = r[2] ^ r[3];
    return r;
  endfunction

  function automatic logic [7:0] bld_exp(logic [7:0] op, logic [2:0] s, logic t);
    logic [7:0] r;
    r = op; r[s] = t;
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    io_wr = 0; bst = 0; irq_take = 0; reti = 0; alu_upd = 0;
    io_addr = ADDR;
  endtask

  task automatic step();
    #1;
    chk("R2 rdata", io_rdata, (io_addr == ADDR) ? m : 8'h00);
    chk("R6 pend", irq_pend, m[7] ? (irq_req & irq_mask) : '0);
    chk("R10 bld", bld_out, bld_exp(opnd, bit_sel, m[6]));
    m = model(m);
    @(posedge clk); @(negedge clk);
    chk("R3 R4 R7 R8 R9 flags", flags, m);
    chk("R5 sign", flags[4], flags[2] ^ flags[3]);
    idle();
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog (all) act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1357));
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    m = 8'h00;
    chk("R1 reset", flags, 8'h00);

    // R3: full write, S recomputed -> 0xEF
    io_wr = 1; io_wdata = 8'hFF; step();
    chk("R3 ff write", flags, 8'hEF);
    // R2: foreign address write ignored
    io_addr = 6'h05; io_wr = 1; io_wdata = 8'h00; step();
    chk("R2 foreign", flags, 8'hEF);
    // R7: accept beats written I, other bits load
    io_wr = 1; io_wdata = 8'hC1; irq_take = 1; step();
    chk("R7 take vs write", flags, 8'h41);
    // R8: return and accept together -> I=0
    reti = 1; irq_take = 1; step();
    chk("R8 both", flags[7], 1'b0);
    reti = 1; step();
    chk("R8 reti", flags[7], 1'b1);
    // R4: masked ALU update of N only
    alu_upd = 8'h04; alu_val = 8'hFF; step();
    chk("R4 n only", flags, 8'hD5);
    // R9: bit-store of bit 5
    bst = 1; opnd = 8'h00; bit_sel = 3'd5; step();
    chk("R9 bst", flags[6], 1'b0);

    for (int k = 0; k < 600; k++) begin
      io_addr  = ($urandom % 5 == 0) ? AW'($urandom) : ADDR;
      io_wr    = ($urandom % 4 == 0);
      io_wdata = 8'($urandom);
      alu_upd  = ($urandom % 2) ? 8'($urandom) : 8'h00;
      alu_val  = 8'($urandom);
      bst      = ($urandom % 4 == 0);
      bit_sel  = 3'($urandom);
      opnd     = 8'($urandom);
      irq_req  = NIRQ'($urandom);
      irq_mask = NIRQ'($urandom);
      irq_take = ($urandom % 8 == 0);
      reti     = ($urandom % 6 == 0);
      step();
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule